// File: doc/BRIEF.md
# Programmable Timer and Auto-Interrupt Generator

This block turns one slow base tick into the periodic events a processor subsystem needs. Every tick advances a free-running tick counter. Fixed taps of that counter produce a level-1 auto-interrupt every 64 ticks, a level-3 auto-interrupt every 16384 ticks, a keyboard-scan strobe every 128 ticks and, on second-generation hardware, a frame flag that flips every 192 ticks. An 8-bit programmable timer advances at one of four prescaled rates. When it passes through zero it reloads from a software-written value, and it requests a level-5 interrupt each time an advance leaves it at zero.

A level-4 request collects the link port's events. It is the OR of four enable/status pairs, and the link control register can switch it off as a whole. One global mask bit blocks levels 1, 3 and 5. On second-generation hardware a gate in a second control register also blocks them. The hardware generation is a static input that is set before reset is released. Software writes four 8-bit registers through a simple write port. Each interrupt request is a one-cycle pulse, registered on the clock edge that takes the qualifying tick.

Top module: `autoint_timer`

## Requirements
- R1: While reset is asserted, and after it is released, the tick counter, the timer value, the frame flag, the keyboard strobe and all four interrupt outputs are zero.
- R2: The prescaler select (control bits 5:4) picks a timer advance every 1, 16, 128 or 8192 base ticks for codes 0, 1, 2 and 3. An advance happens on a tick whose updated tick count is a multiple of that period.
- R3: The timer advances only on a tick when control bit 1 (oscillator on) and control bit 3 (timer on) are both set. Otherwise its value holds.
- R4: On an advance, a timer value of 0x00 loads the reload register. Any other value increments by one, and 0xFF wraps to 0x00.
- R5: irq_l5 pulses on each advance that leaves the timer at 0x00.
- R6: irq_l1 pulses on every tick whose updated tick count is a multiple of 64, but only while control bit 1 is set.
- R7: irq_l3 pulses on every tick whose updated tick count is a multiple of 16384, but only while control bits 1 and 2 are both set.
- R8: Control bit 7 set blocks irq_l1, irq_l3 and irq_l5. The timer keeps counting while they are blocked.
- R9: With hw_gen2 high, second control register bit 2 set with bit 1 clear also blocks irq_l1, irq_l3 and irq_l5. With hw_gen2 low this gate has no effect.
- R10: irq_l4 pulses on a tick when link control bit 6 is clear and at least one pair holds: link control bit 3 with link status bit 7, bit 2 with status bit 3, bit 1 with status bit 6, or bit 0 with status bit 5.
- R11: kbd_strobe pulses on every tick whose updated tick count is a multiple of 128. The oscillator bit does not affect it.
- R12: With hw_gen2 high, frame_flag flips on every tick whose updated tick count is a multiple of 192. With hw_gen2 low it stays at zero.
- R13: A write with wr_en high stores wr_data in the register that wr_addr selects: 0 is control, 1 is reload, 2 is link control, 3 is second control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_gen2 | input | 1 | Selects second-generation behaviour; static after reset |
| tick_in | input | 1 | Base tick, one clock wide per tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| link_status | input | 8 | Status byte from the link port |
| timer_val | output | 8 | Current programmable timer value |
| irq_l1 | output | 1 | Level-1 interrupt request pulse |
| irq_l3 | output | 1 | Level-3 interrupt request pulse |
| irq_l4 | output | 1 | Level-4 interrupt request pulse |
| irq_l5 | output | 1 | Level-5 interrupt request pulse |
| kbd_strobe | output | 1 | Keyboard-scan strobe pulse |
| frame_flag | output | 1 | Frame toggle flag |

## Verification
The bench builds the block with its default parameters: a 16-bit tick counter, prescaler shifts 0, 4, 7 and 13, and interrupt taps at 64 and 16384 ticks. The tick input is held high over long runs, so a full level-3 period and the slowest prescaler period of 8192 ticks fit well inside the run. This also lets the bench observe timer wrap sequences, the stuck-at-zero case of a zero reload, and the frame flag on its 192-tick boundary, all at the real rates.

// File: rtl/autoint_pkg.sv
`timescale 1ns/1ps
package autoint_pkg;
    localparam int REG_W = 8;

    // register select codes
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_LINK   = 2'd2;
    localparam logic [1:0] ADDR_GEN2   = 2'd3;

    // control register fields
    localparam int CTL_OSC_ON  = 1;
    localparam int CTL_L3_ON   = 2;
    localparam int CTL_TMR_ON  = 3;
    localparam int CTL_PSEL_LO = 4;
    localparam int CTL_MASK    = 7;

    // second control register gate bits
    localparam int G2_LOCK = 2;
    localparam int G2_RUN  = 1;

    // link control disable bit and the enable/status pairs
    localparam int LNK_OFF   = 6;
    localparam int LNK_PAIRS = 4;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] reload;
        logic [REG_W-1:0] link_ctl;
        logic [REG_W-1:0] gen2_ctl;
    } regs_t;

    function automatic int lnk_en_bit(input int i);
        case (i)
            0:       return 3;
            1:       return 2;
            2:       return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int lnk_st_bit(input int i);
        case (i)
            0:       return 7;
            1:       return 3;
            2:       return 6;
            default: return 5;
        endcase
    endfunction
endpackage

// File: rtl/autoint_regs.sv
`timescale 1ns/1ps
module autoint_regs
    import autoint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output regs_t            regs
);
    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL:   regs_d.ctrl     = wr_data;
                ADDR_RELOAD: regs_d.reload   = wr_data;
                ADDR_LINK:   regs_d.link_ctl = wr_data;
                default:     regs_d.gen2_ctl = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;
endmodule

// File: rtl/autoint_tick_base.sv
`timescale 1ns/1ps
module autoint_tick_base #(
    parameter int CNT_W     = 16,
    parameter int L1_LOG    = 6,
    parameter int L3_LOG    = 14,
    parameter int KBD_LOG   = 7,
    parameter int FRAME_DIV = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gen2,
    output logic [CNT_W-1:0] cnt_cur,
    output logic [CNT_W-1:0] cnt_next,
    output logic             hit_l1,
    output logic             hit_l3,
    output logic             kbd_strobe,
    output logic             frame_flag
);
    localparam int FD_W = $clog2(FRAME_DIV);
    localparam logic [CNT_W-1:0] L1_MASK  = CNT_W'((1 << L1_LOG) - 1);
    localparam logic [CNT_W-1:0] L3_MASK  = CNT_W'((1 << L3_LOG) - 1);
    localparam logic [CNT_W-1:0] KBD_MASK = CNT_W'((1 << KBD_LOG) - 1);
    localparam logic [FD_W-1:0]  FD_LAST  = FD_W'(FRAME_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [FD_W-1:0]  fdiv;
        logic             kbd;
        logic             frame;
    } base_t;

    base_t st_d, st_q;

    always_comb begin
        cnt_next = st_q.cnt + CNT_W'(1);
        hit_l1   = tick && ((cnt_next & L1_MASK) == '0);
        hit_l3   = tick && ((cnt_next & L3_MASK) == '0);

        st_d     = st_q;
        st_d.kbd = tick && ((cnt_next & KBD_MASK) == '0);
        if (tick) begin
            st_d.cnt = cnt_next;
            // fdiv follows the tick count modulo FRAME_DIV
            if (st_q.fdiv == FD_LAST) begin
                st_d.fdiv = '0;
                if (gen2) st_d.frame = !st_q.frame;
            end else begin
                st_d.fdiv = st_q.fdiv + FD_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_cur    = st_q.cnt;
    assign kbd_strobe = st_q.kbd;
    assign frame_flag = st_q.frame;
endmodule

// File: rtl/autoint_prog_timer.sv
`timescale 1ns/1ps
module autoint_prog_timer #(
    parameter int CNT_W = 16,
    parameter int TMR_W = 8,
    parameter int PS0   = 0,
    parameter int PS1   = 4,
    parameter int PS2   = 7,
    parameter int PS3   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [1:0]       psel,
    input  logic             osc_on,
    input  logic             tmr_on,
    input  logic [TMR_W-1:0] reload,
    output logic [TMR_W-1:0] value,
    output logic             zero_evt
);
    localparam logic [CNT_W-1:0] M0 = CNT_W'((1 << PS0) - 1);
    localparam logic [CNT_W-1:0] M1 = CNT_W'((1 << PS1) - 1);
    localparam logic [CNT_W-1:0] M2 = CNT_W'((1 << PS2) - 1);
    localparam logic [CNT_W-1:0] M3 = CNT_W'((1 << PS3) - 1);

    typedef struct packed {
        logic [TMR_W-1:0] val;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CNT_W-1:0] mask;
    logic             adv;

    always_comb begin
        case (psel)
            2'd0:    mask = M0;
            2'd1:    mask = M1;
            2'd2:    mask = M2;
            default: mask = M3;
        endcase

        adv  = tick && osc_on && tmr_on && ((cnt_next & mask) == '0);
        st_d = st_q;
        if (adv) begin
            if (st_q.val == '0) st_d.val = reload;
            else                st_d.val = st_q.val + TMR_W'(1);
        end
        zero_evt = adv && (st_d.val == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.val;
endmodule

// File: rtl/autoint_irq_gate.sv
`timescale 1ns/1ps
module autoint_irq_gate
    import autoint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gen2,
    input  logic             hit_l1,
    input  logic             hit_l3,
    input  logic             zero_evt,
    input  logic             osc_on,
    input  logic             l3_on,
    input  logic             mask_all,
    input  logic             g2_lock,
    input  logic             g2_run,
    input  logic [REG_W-1:0] link_ctl,
    input  logic [REG_W-1:0] link_stat,
    output logic             irq_l1,
    output logic             irq_l3,
    output logic             irq_l4,
    output logic             irq_l5
);
    typedef struct packed {
        logic l1;
        logic l3;
        logic l4;
        logic l5;
    } irq_t;

    irq_t st_d, st_q;
    logic blocked;
    logic [LNK_PAIRS-1:0] pair_hit;
    logic unused_lnk;

    assign unused_lnk = ^{link_ctl[7], link_ctl[5:4], link_stat[4], link_stat[2:0]};

    always_comb begin
        for (int i = 0; i < LNK_PAIRS; i++)
            pair_hit[i] = link_ctl[lnk_en_bit(i)] && link_stat[lnk_st_bit(i)];

        blocked = mask_all || (gen2 && g2_lock && !g2_run);

        st_d.l1 = hit_l1 && osc_on && !blocked;
        st_d.l3 = hit_l3 && osc_on && l3_on && !blocked;
        st_d.l5 = zero_evt && !blocked;
        st_d.l4 = tick && !link_ctl[LNK_OFF] && (|pair_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_l1 = st_q.l1;
    assign irq_l3 = st_q.l3;
    assign irq_l4 = st_q.l4;
    assign irq_l5 = st_q.l5;
endmodule

// File: rtl/autoint_timer.sv
`timescale 1ns/1ps
module autoint_timer
    import autoint_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int L1_LOG    = 6,
    parameter int L3_LOG    = 14,
    parameter int KBD_LOG   = 7,
    parameter int FRAME_DIV = 192,
    parameter int PS0       = 0,
    parameter int PS1       = 4,
    parameter int PS2       = 7,
    parameter int PS3       = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_gen2,
    input  logic       tick_in,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] link_status,
    output logic [7:0] timer_val,
    output logic       irq_l1,
    output logic       irq_l3,
    output logic       irq_l4,
    output logic       irq_l5,
    output logic       kbd_strobe,
    output logic       frame_flag
);
    regs_t            regs;
    logic [CNT_W-1:0] cnt_cur;
    logic [CNT_W-1:0] cnt_next;
    logic             hit_l1;
    logic             hit_l3;
    logic             zero_evt;
    logic             unused_bits;

    assign unused_bits = ^{regs.ctrl[6], regs.ctrl[0], regs.gen2_ctl[7:3], regs.gen2_ctl[0]};

    autoint_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs    (regs)
    );

    autoint_tick_base #(
        .CNT_W     (CNT_W),
        .L1_LOG    (L1_LOG),
        .L3_LOG    (L3_LOG),
        .KBD_LOG   (KBD_LOG),
        .FRAME_DIV (FRAME_DIV)
    ) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_in),
        .gen2       (hw_gen2),
        .cnt_cur    (cnt_cur),
        .cnt_next   (cnt_next),
        .hit_l1     (hit_l1),
        .hit_l3     (hit_l3),
        .kbd_strobe (kbd_strobe),
        .frame_flag (frame_flag)
    );

    autoint_prog_timer #(
        .CNT_W (CNT_W),
        .TMR_W (REG_W),
        .PS0   (PS0),
        .PS1   (PS1),
        .PS2   (PS2),
        .PS3   (PS3)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_in),
        .cnt_next (cnt_next),
        .psel     (regs.ctrl[CTL_PSEL_LO+1:CTL_PSEL_LO]),
        .osc_on   (regs.ctrl[CTL_OSC_ON]),
        .tmr_on   (regs.ctrl[CTL_TMR_ON]),
        .reload   (regs.reload),
        .value    (timer_val),
        .zero_evt (zero_evt)
    );

    autoint_irq_gate u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_in),
        .gen2      (hw_gen2),
        .hit_l1    (hit_l1),
        .hit_l3    (hit_l3),
        .zero_evt  (zero_evt),
        .osc_on    (regs.ctrl[CTL_OSC_ON]),
        .l3_on     (regs.ctrl[CTL_L3_ON]),
        .mask_all  (regs.ctrl[CTL_MASK]),
        .g2_lock   (regs.gen2_ctl[G2_LOCK]),
        .g2_run    (regs.gen2_ctl[G2_RUN]),
        .link_ctl  (regs.link_ctl),
        .link_stat (link_status),
        .irq_l1    (irq_l1),
        .irq_l3    (irq_l3),
        .irq_l4    (irq_l4),
        .irq_l5    (irq_l5)
    );
endmodule

// File: rtl/autoint_timer_chk.sv
`timescale 1ns/1ps
module autoint_timer_chk #(
    parameter int CNT_W   = 16,
    parameter int KBD_LOG = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hw_gen2,
    input logic             tick_in,
    input logic [7:0]       ctrl,
    input logic [7:0]       g2ctl,
    input logic [7:0]       lctl,
    input logic [CNT_W-1:0] cnt,
    input logic [7:0]       timer_val,
    input logic             irq_l1,
    input logic             irq_l3,
    input logic             irq_l4,
    input logic             irq_l5,
    input logic             kbd_strobe,
    input logic             frame_flag
);
    localparam logic [CNT_W-1:0] KMASK = CNT_W'((1 << KBD_LOG) - 1);

    // R5
    l5_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_l5 |-> (timer_val == 8'h00));

    // R8
    global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_l1 || irq_l3 || irq_l5) |-> !$past(ctrl[7]));

    // R6
    l1_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_l1 |-> ($past(tick_in) && $past(ctrl[1])));

    // R7
    l3_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_l3 |-> (irq_l1 && $past(ctrl[2])));

    // R9
    gen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_l1 || irq_l3 || irq_l5) && hw_gen2) |-> !($past(g2ctl[2]) && !$past(g2ctl[1])));

    // R3
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_in) |-> $stable(timer_val));

    // R10
    l4_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_l4 |-> ($past(tick_in) && !$past(lctl[6])));

    // R11
    kbd_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_strobe |-> ((cnt & KMASK) == '0));

    // R12
    frame_gen1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_gen2 |-> !frame_flag);
endmodule

bind autoint_timer autoint_timer_chk #(.CNT_W(CNT_W), .KBD_LOG(KBD_LOG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_gen2    (hw_gen2),
    .tick_in    (tick_in),
    .ctrl       (regs.ctrl),
    .g2ctl      (regs.gen2_ctl),
    .lctl       (regs.link_ctl),
    .cnt        (cnt_cur),
    .timer_val  (timer_val),
    .irq_l1     (irq_l1),
    .irq_l3     (irq_l3),
    .irq_l4     (irq_l4),
    .irq_l5     (irq_l5),
    .kbd_strobe (kbd_strobe),
    .frame_flag (frame_flag)
);

// File: tb/sim_autoint_timer.sv
`timescale 1ns/1ps
module sim_autoint_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_gen2 = 1'b0;
    logic       tick_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] link_status = 8'h00;
    logic [7:0] timer_val;
    logic       irq_l1, irq_l3, irq_l4, irq_l5, kbd_strobe, frame_flag;

    int checks = 0;
    int errors = 0;
    int n1 = 0, n3 = 0, n4 = 0, n5 = 0, nk = 0;

    always #2.5 clk = !clk;

    autoint_timer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_gen2     (hw_gen2),
        .tick_in     (tick_in),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .link_status (link_status),
        .timer_val   (timer_val),
        .irq_l1      (irq_l1),
        .irq_l3      (irq_l3),
        .irq_l4      (irq_l4),
        .irq_l5      (irq_l5),
        .kbd_strobe  (kbd_strobe),
        .frame_flag  (frame_flag)
    );

    // pulse counters, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n1 <= n1 + int'(irq_l1);
            n3 <= n3 + int'(irq_l3);
            n4 <= n4 + int'(irq_l4);
            n5 <= n5 + int'(irq_l5);
            nk <= nk + int'(kbd_strobe);
        end
    end

    typedef struct packed {
        logic [1:0]  psel;
        logic [7:0]  reload;
        logic [15:0] nticks;
        logic [7:0]  exp_val;
        logic [7:0]  exp_l5;
        logic [7:0]  exp_l1;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 8'hF0, 16'd20,   8'hF2, 8'd1, 8'd0},
        '{2'd1, 8'hFE, 16'd80,   8'hFF, 8'd1, 8'd1},
        '{2'd2, 8'h80, 16'd300,  8'h81, 8'd0, 8'd4},
        '{2'd0, 8'h00, 16'd5,    8'h00, 8'd5, 8'd0},
        '{2'd0, 8'hFF, 16'd6,    8'h00, 8'd3, 8'd0},
        '{2'd3, 8'h40, 16'd8192, 8'h40, 8'd0, 8'd128}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic gen);
        @(negedge clk);
        rst_n   = 1'b0;
        hw_gen2 = gen;
        tick_in = 1'b0;
        wr_en   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick_in = 1'b1;
        repeat (n) @(negedge clk);
        tick_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #950000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int b1, b3, b4, b5, bk;

        // R1 reset state
        do_reset(1'b0);
        chk("R1 timer", int'(timer_val), 0);
        chk("R1 irqs", int'({irq_l1, irq_l3, irq_l4, irq_l5}), 0);
        chk("R1 kbd/frame", int'({kbd_strobe, frame_flag}), 0);

        // R2 R4 R5 R6 R13: vector walk (ctrl = osc+timer on, psel in bits 5:4)
        for (int i = 0; i < NVEC; i++) begin
            do_reset(1'b0);
            wr(2'd1, VECS[i].reload);
            wr(2'd0, 8'h0A | {2'b00, VECS[i].psel, 4'b0000});
            b1 = n1; b5 = n5;
            run_ticks(int'(VECS[i].nticks));
            chk($sformatf("R2 R4 R13 vec%0d timer", i), int'(timer_val), int'(VECS[i].exp_val));
            chk($sformatf("R5 vec%0d l5 count", i), n5 - b5, int'(VECS[i].exp_l5));
            chk($sformatf("R6 vec%0d l1 count", i), n1 - b1, int'(VECS[i].exp_l1));
        end

        // R3 / R6: oscillator off, timer on -> no advance, no level 1
        do_reset(1'b0);
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h08);
        b1 = n1;
        run_ticks(128);
        chk("R3 osc off timer", int'(timer_val), 0);
        chk("R6 osc off l1", n1 - b1, 0);
        // R3: oscillator on, timer off
        wr(2'd0, 8'h02);
        run_ticks(10);
        chk("R3 timer off", int'(timer_val), 0);

        // R8: global mask, timer still runs (reload FF -> FF,00 alternating)
        do_reset(1'b0);
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h8E);
        b1 = n1; b3 = n3; b5 = n5;
        run_ticks(16384);
        chk("R8 masked l1", n1 - b1, 0);
        chk("R8 masked l3", n3 - b3, 0);
        chk("R8 masked l5", n5 - b5, 0);
        chk("R8 timer still counts", int'(timer_val), 0);
        run_ticks(1);
        chk("R8 timer advanced", int'(timer_val), 255);

        // R7: level 3 with and without its enable
        do_reset(1'b0);
        wr(2'd0, 8'h06);
        b1 = n1; b3 = n3;
        run_ticks(16384);
        chk("R7 l3 enabled", n3 - b3, 1);
        chk("R6 l1 over 16384", n1 - b1, 256);
        do_reset(1'b0);
        wr(2'd0, 8'h02);
        b3 = n3;
        run_ticks(16384);
        chk("R7 l3 disabled", n3 - b3, 0);

        // R9: second-generation gate
        do_reset(1'b1);
        wr(2'd3, 8'h04);
        wr(2'd0, 8'h02);
        b1 = n1;
        run_ticks(64);
        chk("R9 gen2 gated", n1 - b1, 0);
        wr(2'd3, 8'h06);
        b1 = n1;
        run_ticks(64);
        chk("R9 gen2 ungated", n1 - b1, 1);
        do_reset(1'b0);
        wr(2'd3, 8'h04);
        wr(2'd0, 8'h02);
        b1 = n1;
        run_ticks(64);
        chk("R9 gen1 ignores gate", n1 - b1, 1);

        // R10: link pairs
        do_reset(1'b0);
        wr(2'd2, 8'h01); link_status = 8'h20;
        b4 = n4; run_ticks(4);
        chk("R10 pair bit0/5", n4 - b4, 4);
        wr(2'd2, 8'h41);
        b4 = n4; run_ticks(4);
        chk("R10 link off", n4 - b4, 0);
        wr(2'd2, 8'h08); link_status = 8'h40;
        b4 = n4; run_ticks(4);
        chk("R10 mismatched pair", n4 - b4, 0);
        link_status = 8'h80;
        b4 = n4; run_ticks(4);
        chk("R10 pair bit3/7", n4 - b4, 4);
        wr(2'd2, 8'h04); link_status = 8'h08;
        b4 = n4; run_ticks(3);
        chk("R10 pair bit2/3", n4 - b4, 3);
        wr(2'd2, 8'h02); link_status = 8'h40;
        b4 = n4; run_ticks(2);
        chk("R10 pair bit1/6", n4 - b4, 2);
        link_status = 8'h00;

        // R11: keyboard strobe independent of oscillator bit
        do_reset(1'b0);
        bk = nk;
        run_ticks(256);
        chk("R11 kbd strobes", nk - bk, 2);

        // R12: frame flag
        do_reset(1'b1);
        run_ticks(191);
        chk("R12 before boundary", int'(frame_flag), 0);
        run_ticks(1);
        chk("R12 first toggle", int'(frame_flag), 1);
        run_ticks(192);
        chk("R12 second toggle", int'(frame_flag), 0);
        do_reset(1'b0);
        run_ticks(192);
        chk("R12 gen1 flag", int'(frame_flag), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule